// File: doc/BRIEF.md
# Successive-Approximation Conversion and Power-State Controller

This block sequences one successive-approximation conversion at a time and decides the power state of the converter around it. A conversion is requested either by a rising edge on an external convert-start pin or by a one-cycle software start pulse. Once a request is accepted, the block raises busy and drives a 12-bit trial code to an external DAC. It reads a comparator each cycle and settles one bit per cycle, most significant bit first. The conversion always occupies a fixed frame of 18 master-clock cycles. At the end of the frame it publishes the result and drops busy.

Between conversions the block reports one of three power states: normal, partial power-down or full power-down. The state is chosen from an active-low sleep pin and a 2-bit power-management field. Any power-down is held off while a conversion runs and takes effect in the same cycle that busy falls. A start request that arrives while the block is powered down wakes it, and the conversion runs with no extra latency.

After each conversion the block enforces a short acquisition window. Start requests that fall inside that window are ignored. The analog sampler, the DAC and the reference are outside this block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A rising edge on `conv_start_i` is accepted when the block is idle and outside the acquisition window. A level held high does not retrigger. `busy_o` is 1 from the cycle after the accepting clock edge.
- R2: Once raised, `busy_o` stays high for exactly 18 clock cycles.
- R3: While a conversion runs, `dac_code_o` carries the trial code. It is 0x800 in the first busy cycle. In busy cycle k (k = 0..11), bit 11-k is kept when `cmp_i` = 1 (input at or above the trial code) and cleared when `cmp_i` = 0, and bit 10-k is then set. The final code appears on `result_o` when busy falls and is held unchanged until the next conversion ends.
- R4: Edges on `conv_start_i` and pulses on `sw_start_i` while `busy_o` is high are ignored. The running conversion keeps its 18-cycle length and no second conversion follows.
- R5: A `sw_start_i` pulse that is accepted starts a conversion and sets `sw_bit_o`. `sw_bit_o` returns to 0 in the cycle `busy_o` falls.
- R6: For the first 2 clock edges after the one that drops `busy_o`, start requests are ignored. A request sampled at the third edge is accepted.
- R7: `pstate_o` encodes 00 = normal, 01 = partial, 10 = full. The value 11 never appears. When the block is idle and `sleep_n_i` = 1, `pm_mode_i` = 10 gives full, 11 gives partial, and 00 or 01 give normal. The state follows the inputs one cycle later.
- R8: When the block is idle and `sleep_n_i` = 0, `pstate_o` is full, whatever `pm_mode_i` holds.
- R9: While `busy_o` is high, `pstate_o` is normal, even if sleep or power-down is requested. The deferred low-power state appears in the same cycle `busy_o` falls.
- R10: A start request accepted while powered down gives `busy_o` = 1 and `pstate_o` = normal in the next cycle.
- R11: After synchronous reset, `busy_o`, `sw_bit_o`, `dac_code_o` and `result_o` are 0 and `pstate_o` is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_i | input | 1 | Convert-start pin; its rising edge requests a conversion |
| sw_start_i | input | 1 | One-cycle software start pulse |
| sleep_n_i | input | 1 | Active-low sleep request |
| pm_mode_i | input | 2 | Power-management field (10 full, 11 partial) |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |
| dac_code_o | output | 12 | Trial code to the DAC |
| result_o | output | 12 | Last completed conversion result |
| busy_o | output | 1 | High while a conversion runs |
| sw_bit_o | output | 1 | Software start bit; clears at end of conversion |
| pstate_o | output | 2 | Power state: 00 normal, 01 partial, 10 full |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `cmp_i` is a settled function of the current `dac_code_o`, so it must not lag it by a cycle. The bench models the analog input as a 12-bit value and derives `cmp_i` combinationally from `dac_code_o`. It changes every input only on the falling clock edge. The checks on start-cause and sleep-state compare a port with its value one or two cycles earlier, so the bench holds each request stable for a whole cycle.

// File: rtl/sar_pwr_pkg.sv
// Shared encodings for the conversion and power-state controller.
// Assumes: the power-state output is a 2-bit code and the mode field is 2 bits.
package sar_pwr_pkg;
    typedef enum logic [1:0] {
        PS_NORMAL  = 2'b00,
        PS_PARTIAL = 2'b01,
        PS_FULL    = 2'b10
    } pstate_e;

    localparam logic [1:0] PM_FULL    = 2'b10;
    localparam logic [1:0] PM_PARTIAL = 2'b11;
endpackage

// File: rtl/sar_start_gate.sv
// Accepts conversion requests: convert-start rising edges and software pulses.
// Requests are dropped while busy and during the acquisition window after a
// conversion. Also keeps the self-clearing software start bit.
// Assumes: conv_start_i and sw_start_i are synchronous to clk.
module sar_start_gate #(
    parameter int ACQ_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start_i,
    input  logic sw_start_i,
    input  logic busy_i,
    input  logic conv_end_i,
    output logic start_go_o,
    output logic sw_bit_o
);
    localparam int AW = $clog2(ACQ_CYCLES + 2);

    logic          cs_q;
    logic [AW-1:0] acq_q;
    logic          sw_bit_q;
    logic          rise;

    assign rise       = conv_start_i & ~cs_q;
    assign start_go_o = (rise | sw_start_i) & ~busy_i & (acq_q == '0);
    assign sw_bit_o   = sw_bit_q;

    // Previous convert-start level; reset high so a pin held high at reset is not taken as an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= conv_start_i;
    end

    // Acquisition hold-off counter, loaded when a conversion ends.
    always_ff @(posedge clk) begin
        if (!rst_n)             acq_q <= '0;
        else if (conv_end_i)    acq_q <= AW'(ACQ_CYCLES);
        else if (acq_q != '0)   acq_q <= acq_q - 1'b1;
    end

    // Software start bit: set by an accepted pulse, cleared at end of conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)                        sw_bit_q <= 1'b0;
        else if (start_go_o && sw_start_i) sw_bit_q <= 1'b1;
        else if (conv_end_i)               sw_bit_q <= 1'b0;
    end
endmodule

// File: rtl/sar_bit_seq.sv
// Successive-approximation sequencer. It decides one bit per cycle for the
// first WIDTH cycles of a fixed CONV_CYCLES frame and publishes the result at
// the end of the frame.
// Assumes: CONV_CYCLES > WIDTH, and cmp_i reflects the current trial code.
module sar_bit_seq #(
    parameter int WIDTH       = 12,
    parameter int CONV_CYCLES = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic             conv_end_o,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] result_o
);
    localparam int CW = $clog2(CONV_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0]    cnt_q;
    logic             busy_q;
    logic [WIDTH-1:0] trial_q, trial_nx, result_q;

    assign conv_end_o = busy_q && (cnt_q == LAST);
    assign busy_o     = busy_q;
    assign trial_o    = trial_q;
    assign result_o   = result_q;

    // Next trial code: settle the current bit, then tentatively set the next lower one.
    always_comb begin
        trial_nx = trial_q;
        if (busy_q && int'(cnt_q) < WIDTH) begin
            for (int b = 0; b < WIDTH; b++) begin
                if (b == WIDTH - 1 - int'(cnt_q) && !cmp_i) trial_nx[b] = 1'b0;
                if (b == WIDTH - 2 - int'(cnt_q))           trial_nx[b] = 1'b1;
            end
        end
    end

    // Frame counter, busy flag, trial register and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            busy_q   <= 1'b0;
            trial_q  <= '0;
            result_q <= '0;
        end else if (start_i) begin
            cnt_q    <= '0;
            busy_q   <= 1'b1;
            trial_q  <= {1'b1, {(WIDTH-1){1'b0}}};
        end else if (busy_q) begin
            cnt_q   <= cnt_q + 1'b1;
            trial_q <= trial_nx;
            if (conv_end_o) begin
                busy_q   <= 1'b0;
                result_q <= trial_q;
            end
        end
    end
endmodule

// File: rtl/sar_pwr_state.sv
// Power-state decision. Reports normal while a conversion is active or starting.
// When idle, it reports the state chosen by the sleep pin, then by the mode field.
// Assumes: start_i is only asserted when the block is idle.
module sar_pwr_state
    import sar_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       busy_i,
    input  logic       conv_end_i,
    input  logic       sleep_n_i,
    input  logic [1:0] pm_i,
    output logic [1:0] pstate_o
);
    pstate_e idle_ps, ps_q;
    logic    active;

    assign active   = start_i | (busy_i & ~conv_end_i);
    assign pstate_o = ps_q;

    // Idle state: sleep pin overrides the mode field.
    always_comb begin
        if (!sleep_n_i) idle_ps = PS_FULL;
        else begin
            case (pm_i)
                PM_FULL:    idle_ps = PS_FULL;
                PM_PARTIAL: idle_ps = PS_PARTIAL;
                default:    idle_ps = PS_NORMAL;
            endcase
        end
    end

    // Registered power state; power-down is deferred while active.
    always_ff @(posedge clk) begin
        if (!rst_n)      ps_q <= PS_NORMAL;
        else if (active) ps_q <= PS_NORMAL;
        else             ps_q <= idle_ps;
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
// Top level of the conversion and power-state controller. It joins the start
// gate, the bit sequencer and the power-state decision.
// Assumes: all inputs are synchronous to clk; the DAC and comparator are external.
module sar_conv_ctrl #(
    parameter int WIDTH       = 12,
    parameter int CONV_CYCLES = 18,
    parameter int ACQ_CYCLES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start_i,
    input  logic             sw_start_i,
    input  logic             sleep_n_i,
    input  logic [1:0]       pm_mode_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic [WIDTH-1:0] result_o,
    output logic             busy_o,
    output logic             sw_bit_o,
    output logic [1:0]       pstate_o
);
    logic start_go, busy, conv_end;

    assign busy_o = busy;

    sar_start_gate #(.ACQ_CYCLES(ACQ_CYCLES)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_start_i (conv_start_i),
        .sw_start_i   (sw_start_i),
        .busy_i       (busy),
        .conv_end_i   (conv_end),
        .start_go_o   (start_go),
        .sw_bit_o     (sw_bit_o)
    );

    sar_bit_seq #(.WIDTH(WIDTH), .CONV_CYCLES(CONV_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_go),
        .cmp_i      (cmp_i),
        .busy_o     (busy),
        .conv_end_o (conv_end),
        .trial_o    (dac_code_o),
        .result_o   (result_o)
    );

    sar_pwr_state u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_go),
        .busy_i     (busy),
        .conv_end_i (conv_end),
        .sleep_n_i  (sleep_n_i),
        .pm_i       (pm_mode_i),
        .pstate_o   (pstate_o)
    );
endmodule

// File: rtl/sar_conv_chk.sv
// Property checker for the conversion controller, bound to the top module.
// Assumes: reset is synchronous and active low.
module sar_conv_chk #(
    parameter int WIDTH       = 12,
    parameter int CONV_CYCLES = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_start_i,
    input logic             sw_start_i,
    input logic             sleep_n_i,
    input logic             busy_o,
    input logic             sw_bit_o,
    input logic [WIDTH-1:0] result_o,
    input logic [1:0]       pstate_o
);
    int unsigned run_len;

    // Length of the current busy run, counted independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= 0;
        else if (busy_o) run_len <= run_len + 1;
        else             run_len <= 0;
    end

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (($past(conv_start_i) && !$past(conv_start_i, 2)) || $past(sw_start_i))); // R1

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == CONV_CYCLES)); // R2

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> $stable(result_o)); // R3

    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !sw_bit_o); // R5

    AST_PS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pstate_o != 2'b11); // R7

    AST_SLEEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o) && $past(!sleep_n_i)) |-> (pstate_o == 2'b10)); // R8

    AST_BUSY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (pstate_o == 2'b00)); // R9
endmodule

bind sar_conv_ctrl sar_conv_chk #(.WIDTH(WIDTH), .CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_start_i (conv_start_i),
    .sw_start_i   (sw_start_i),
    .sleep_n_i    (sleep_n_i),
    .busy_o       (busy_o),
    .sw_bit_o     (sw_bit_o),
    .result_o     (result_o),
    .pstate_o     (pstate_o)
);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n, conv, sw, sleep_n, cmp;
    logic [1:0]  pm;
    logic [11:0] ana, dac, res;
    logic        busy, swb;
    logic [1:0]  ps;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    localparam logic [1:0] NRM = 2'b00, PRT = 2'b01, FUL = 2'b10;

    // {analog value, mode field, expected idle state}
    localparam logic [15:0] VEC [8] = '{
        {12'h000, 2'b00, NRM}, {12'hFFF, 2'b01, NRM}, {12'h800, 2'b10, FUL},
        {12'h7FF, 2'b11, PRT}, {12'h001, 2'b00, NRM}, {12'hA5C, 2'b10, FUL},
        {12'h3C3, 2'b11, PRT}, {12'hFFE, 2'b01, NRM}
    };

    always #5 clk = ~clk;
    assign cmp = (ana >= dac);

    sar_conv_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .conv_start_i(conv), .sw_start_i(sw),
        .sleep_n_i(sleep_n), .pm_mode_i(pm), .cmp_i(cmp), .dac_code_o(dac),
        .result_o(res), .busy_o(busy), .sw_bit_o(swb), .pstate_o(ps)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Counts busy cycles from the current negedge; ends on the negedge after busy falls.
    task automatic wait_busy(output int n, input bit chk_ps);
        n = 0;
        while (busy && n < 40) begin
            if (chk_ps) chk(ps == NRM, "R9 normal while busy", ps, NRM);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic conv_run(input logic [11:0] v, output int n, output logic [11:0] d0);
        ana = v;
        conv = 1'b1;
        @(negedge clk);
        conv = 1'b0;
        d0 = dac;
        wait_busy(n, 1'b0);
    endtask

    task automatic acq_wait();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        logic [11:0] d0;
        rst_n = 1'b0; conv = 1'b0; sw = 1'b0; sleep_n = 1'b1; pm = 2'b00; ana = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy, "R11 busy", busy, 0);
        chk(!swb, "R11 sw bit", swb, 0);
        chk(dac == 0, "R11 dac", dac, 0);
        chk(res == 0, "R11 result", res, 0);
        chk(ps == NRM, "R11 pstate", ps, NRM);

        // Vector table: R1 R2 R3 R7
        foreach (VEC[i]) begin
            pm = VEC[i][3:2];
            @(negedge clk);
            conv_run(VEC[i][15:4], n, d0);
            chk(d0 == 12'h800, "R3 first trial", d0, 12'h800);
            chk(n == 18, "R2 busy length", n, 18);
            chk(res == VEC[i][15:4], "R3 result", res, VEC[i][15:4]);
            chk(ps == VEC[i][1:0], "R7 idle state", ps, VEC[i][1:0]);
            acq_wait();
        end
        pm = 2'b00;
        @(negedge clk);

        // R1: a level held high does not retrigger
        conv_run(12'h123, n, d0);
        conv = 1'b1;
        acq_wait();
        repeat (3) @(negedge clk);
        chk(!busy, "R1 held level no restart", busy, 0);
        conv = 1'b0;
        acq_wait();

        // R4: requests during a conversion are ignored
        ana = 12'h5A5;
        conv = 1'b1;
        @(negedge clk);
        conv = 1'b0;
        n = 0;
        while (busy && n < 40) begin
            if (n == 3) conv = 1'b1;
            if (n == 6) conv = 1'b0;
            if (n == 7) sw = 1'b1;
            if (n == 8) sw = 1'b0;
            n++;
            @(negedge clk);
        end
        chk(n == 18, "R4 length kept", n, 18);
        chk(!swb, "R4 sw bit untouched", swb, 0);
        chk(res == 12'h5A5, "R4 result", res, 12'h5A5);
        repeat (4) @(negedge clk);
        chk(!busy, "R4 no second conversion", busy, 0);

        // R6: acquisition window
        conv_run(12'h0F0, n, d0);
        conv = 1'b1;
        @(negedge clk);
        chk(!busy, "R6 request in window ignored", busy, 0);
        conv = 1'b0;
        @(negedge clk);
        conv = 1'b1;
        @(negedge clk);
        chk(busy, "R6 request after window accepted", busy, 1);
        conv = 1'b0;
        wait_busy(n, 1'b0);
        chk(res == 12'h0F0, "R6 result", res, 12'h0F0);
        acq_wait();

        // R5: software start
        ana = 12'hC01;
        sw = 1'b1;
        @(negedge clk);
        sw = 1'b0;
        chk(busy, "R5 sw start busy", busy, 1);
        chk(swb, "R5 sw bit set", swb, 1);
        wait_busy(n, 1'b0);
        chk(!swb, "R5 sw bit cleared", swb, 0);
        chk(res == 12'hC01, "R5 result", res, 12'hC01);
        chk(n == 18, "R5 length", n, 18);
        acq_wait();

        // R7 / R8: idle mode changes
        pm = 2'b11; @(negedge clk);
        chk(ps == PRT, "R7 partial", ps, PRT);
        pm = 2'b10; @(negedge clk);
        chk(ps == FUL, "R7 full", ps, FUL);
        pm = 2'b01; @(negedge clk);
        chk(ps == NRM, "R7 normal for 01", ps, NRM);
        pm = 2'b11; sleep_n = 1'b0; @(negedge clk);
        chk(ps == FUL, "R8 sleep overrides mode", ps, FUL);
        sleep_n = 1'b1; @(negedge clk);
        chk(ps == PRT, "R8 sleep released", ps, PRT);

        // R9: sleep deferred until the conversion ends
        pm = 2'b00;
        @(negedge clk);
        ana = 12'h777;
        conv = 1'b1;
        @(negedge clk);
        conv = 1'b0;
        sleep_n = 1'b0;
        wait_busy(n, 1'b1);
        chk(ps == FUL, "R9 full at busy fall", ps, FUL);
        chk(res == 12'h777, "R9 result", res, 12'h777);
        acq_wait();

        // R10: wake from full power-down
        ana = 12'h2B4;
        conv = 1'b1;
        @(negedge clk);
        conv = 1'b0;
        chk(busy, "R10 wake busy", busy, 1);
        chk(ps == NRM, "R10 wake normal", ps, NRM);
        wait_busy(n, 1'b1);
        chk(res == 12'h2B4, "R10 result", res, 12'h2B4);
        chk(ps == FUL, "R10 back to full", ps, FUL);
        sleep_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule